// File: doc/BRIEF.md
# Dual-Mode Processor Counter-Timer Channel

This block is one counter-timer channel for a single processor. An external mode input selects how it behaves. In counter mode it is a limit timer. A count advances once per tick input up to a programmed limit, then wraps to zero, sets a reached flag and raises an interrupt. In user-timer mode the same storage becomes a 63-bit up-counter that never interrupts. Software reads and writes that counter as two 32-bit words, and starts or stops it through a run bit.

The register window has four word offsets, and their meaning changes with the mode. Offset 0 holds the limit in counter mode and the high word of the counter in user-timer mode. Offset 1 holds the count with the reached flag in counter mode and the low word of the counter in user-timer mode. Offset 3 holds the run bit, and offset 2 is unused. Count values sit at bit 9 and above, so bits 8..0 of a count word are always zero. A mode change triggers actions of its own on the clock edge after the mode input changes. The tick prescaler and the register that drives the mode input live outside this block.

Top module: `dmt_channel`

## Requirements
- R1: After reset the channel is in counter mode, the run bit is 1, and the limit, the count and the reached flag are 0. `irq` is 0, `rdata` is 0, and a read of offset 3 returns 1.
- R2: In counter mode, a write to offset 0 sets the limit from bits 30..9, clears the count and deasserts `irq`, and it leaves the reached flag as it is. A read of offset 0 returns the limit in bits 30..9 with all other bits 0, and clears both the reached flag and `irq`.
- R3: In counter mode with a nonzero limit L, each tick adds one unit to the count. The tick that arrives while the count is L-1 wraps the count to 0, sets the reached flag and asserts `irq`. A read of offset 1 returns the count in bits 30..9 and the reached flag in bit 31. With a limit of 0 the count runs freely and neither the reached flag nor `irq` is set.
- R4: In counter mode the count advances on every tick whatever the run bit holds, and writes to offset 1 have no effect.
- R5: A write to offset 3 stores bit 0 as the run bit, in either mode. A read of offset 3 returns the run bit in bit 0, with bits 31..1 zero.
- R6: In user-timer mode, a read of offset 0 returns the reached flag in bit 31 and counter bits 62..32 in bits 30..0. A read of offset 1 returns counter bits 31..9 with bits 8..0 zero. Neither read clears the reached flag.
- R7: In user-timer mode, a write to offset 0 loads counter bits 62..32 from write bits 30..0, and a write to offset 1 loads counter bits 31..9 from write bits 31..9. Either write clears the reached flag.
- R8: In user-timer mode with the run bit at 1, each tick adds one unit at bit 9 and carries from the low word into the high word. A tick at the maximum value 0x7FFFFFFFFFFFFE00 wraps the counter to 0 and sets the reached flag. With the run bit at 0 the counter holds.
- R9: `irq` stays 0 throughout user-timer mode.
- R10: On entry to user-timer mode, `irq` is deasserted and the limit is forced to its maximum, so a later counter-mode read of offset 0 returns 0x7FFFFE00. The counter keeps its value, and it then counts only while the run bit is 1.
- R11: On return to counter mode the count restarts from 0 and advances on every tick, whatever the run bit holds.
- R12: In user-timer mode, a read of offset 1 captures the high word. The next read of offset 0 returns that captured high word. A later high-word read, any write, or a mode change releases the capture, and later reads of offset 0 return the live value.
- R13: `rdata` is registered and holds the value selected by a read on the edge that samples `rd_en`. A read of offset 2 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One count unit (bit 9 weight) per cycle it is high |
| user_mode | input | 1 | 1 selects user-timer mode, 0 selects counter mode |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word offset within the channel window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt, counter mode only |

## Verification
Every result is due one clock edge after its stimulus. Read data appears on the edge that samples `rd_en`. A count step, a wrap, an interrupt change or a register load takes effect on the edge that samples `tick` or `wr_en`. A mode change acts on the first edge after `user_mode` changes, and the bench leaves one more quiet cycle before the next access. The bench drives every input on the falling edge and samples `rdata` and `irq` on the next falling edge, so each check falls exactly one rising edge after its stimulus. Tick bursts hold `tick` for a known number of rising edges, which makes every expected count exact.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

  // Word offsets inside the channel window; decode depends on them.
  typedef enum logic [1:0] {
    OFS_HI_LIM = 2'd0,
    OFS_LO_CNT = 2'd1,
    OFS_SPARE  = 2'd2,
    OFS_RUN    = 2'd3
  } ofs_e;

  // Decoded access strobes handed from the top to the counting core.
  typedef struct packed {
    logic ld_lim;     // counter mode: new limit, count restart
    logic ld_hi;      // user mode: load high word
    logic ld_lo;      // user mode: load low word
    logic ld_run;     // any mode: run bit
    logic rd_lim_clr; // counter mode: limit read acknowledges reach
  } strobe_t;

endpackage

// File: rtl/dmt_mode_ctrl.sv
module dmt_mode_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic user_mode,
  output logic mode_q,
  output logic enter_user,
  output logic leave_user
);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= user_mode;
  end

  // Edge of the mode input relative to the state the channel is in.
  always_comb begin
    enter_user = user_mode & ~mode_q;
    leave_user = ~user_mode & mode_q;
  end

endmodule

// File: rtl/dmt_count_core.sv
module dmt_count_core
  import dmt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int UNIT_LSB = 9,
  parameter int USR_W    = 54,
  parameter int SYS_W    = 22,
  parameter int LO_W     = 23,
  parameter int HI_W     = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              mode_q,
  input  logic              enter_user,
  input  logic              leave_user,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [USR_W-1:0]  cnt,
  output logic [SYS_W-1:0]  lim,
  output logic              reached,
  output logic              run,
  output logic              irq
);

  localparam logic [USR_W-1:0] USR_MAX = {USR_W{1'b1}};
  localparam logic [SYS_W-1:0] SYS_MAX = {SYS_W{1'b1}};

  logic [SYS_W-1:0] sys_term;
  logic             sys_hit;
  logic             usr_hit;
  logic             lim_set;

  always_comb begin
    lim_set  = (lim != '0);
    sys_term = lim_set ? SYS_W'(lim - 1'b1) : SYS_MAX;
    sys_hit  = (cnt[SYS_W-1:0] == sys_term);
    usr_hit  = (cnt == USR_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      lim     <= '0;
      reached <= 1'b0;
      run     <= 1'b1;
      irq     <= 1'b0;
    end else begin
      if (stb.ld_run) run <= wdata[0];
      // Acknowledge first so that a same-cycle reach event still lands.
      if (stb.rd_lim_clr) begin
        reached <= 1'b0;
        irq     <= 1'b0;
      end
      if (enter_user) begin
        irq <= 1'b0;
        lim <= SYS_MAX;
      end else if (leave_user) begin
        cnt <= '0;
      end else if (stb.ld_lim) begin
        lim <= wdata[UNIT_LSB +: SYS_W];
        cnt <= '0;
        irq <= 1'b0;
      end else if (stb.ld_hi) begin
        cnt[USR_W-1:LO_W] <= wdata[HI_W-1:0];
        reached           <= 1'b0;
      end else if (stb.ld_lo) begin
        cnt[LO_W-1:0] <= wdata[DATA_W-1:UNIT_LSB];
        reached       <= 1'b0;
      end else if (tick) begin
        if (mode_q) begin
          if (run) begin
            if (usr_hit) begin
              cnt     <= '0;
              reached <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end else if (sys_hit) begin
          cnt <= '0;
          if (lim_set) begin
            reached <= 1'b1;
            irq     <= 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dmt_read_port.sv
module dmt_read_port
  import dmt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int UNIT_LSB = 9,
  parameter int USR_W    = 54,
  parameter int SYS_W    = 22,
  parameter int LO_W     = 23,
  parameter int HI_W     = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              mode_chg,
  input  logic [1:0]        addr,
  input  logic              mode_q,
  input  logic [USR_W-1:0]  cnt,
  input  logic [SYS_W-1:0]  lim,
  input  logic              reached,
  input  logic              run,
  output logic [DATA_W-1:0] rdata
);

  logic [HI_W-1:0]   snap_hi;
  logic              snap_vld;
  logic [HI_W-1:0]   hi_live;
  logic [HI_W-1:0]   hi_sel;
  logic [DATA_W-1:0] rd_val;
  logic              rd_lo_usr;
  logic              rd_hi_usr;

  always_comb begin
    hi_live   = cnt[USR_W-1:LO_W];
    hi_sel    = snap_vld ? snap_hi : hi_live;
    rd_lo_usr = rd_en & mode_q & (ofs_e'(addr) == OFS_LO_CNT);
    rd_hi_usr = rd_en & mode_q & (ofs_e'(addr) == OFS_HI_LIM);
  end

  always_comb begin
    rd_val = '0;
    unique case (ofs_e'(addr))
      OFS_HI_LIM: begin
        if (mode_q) begin
          rd_val[HI_W-1:0]  = hi_sel;
          rd_val[DATA_W-1]  = reached;
        end else begin
          rd_val[UNIT_LSB +: SYS_W] = lim;
        end
      end
      OFS_LO_CNT: begin
        if (mode_q) begin
          rd_val[DATA_W-1:UNIT_LSB] = cnt[LO_W-1:0];
        end else begin
          rd_val[UNIT_LSB +: SYS_W] = cnt[SYS_W-1:0];
          rd_val[DATA_W-1]          = reached;
        end
      end
      OFS_RUN:   rd_val[0] = run;
      OFS_SPARE: rd_val = '0;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      snap_hi  <= '0;
      snap_vld <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_val;
      if (mode_chg || wr_en) begin
        snap_vld <= 1'b0;
      end else if (rd_lo_usr) begin
        snap_vld <= 1'b1;
        snap_hi  <= hi_live;
      end else if (rd_hi_usr) begin
        snap_vld <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dmt_channel.sv
module dmt_channel
  import dmt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int UNIT_LSB = 9,
  parameter int CNT_BITS = 63,
  parameter int SYS_BITS = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              user_mode,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam int USR_W = CNT_BITS - UNIT_LSB;
  localparam int SYS_W = SYS_BITS - UNIT_LSB;
  localparam int LO_W  = DATA_W - UNIT_LSB;
  localparam int HI_W  = USR_W - LO_W;

  logic             mode_q;
  logic             enter_user;
  logic             leave_user;
  logic             mode_chg;
  logic             wr_ok;
  logic             rd_ok;
  strobe_t          stb;
  logic [USR_W-1:0] cnt;
  logic [SYS_W-1:0] lim;
  logic             reached;
  logic             run;

  dmt_mode_ctrl mode_i (
    .clk        (clk),
    .rst        (rst),
    .user_mode  (user_mode),
    .mode_q     (mode_q),
    .enter_user (enter_user),
    .leave_user (leave_user)
  );

  // Accesses in the cycle of a mode change are dropped for the core.
  always_comb begin
    mode_chg       = enter_user | leave_user;
    wr_ok          = wr_en & ~mode_chg;
    rd_ok          = rd_en & ~mode_chg;
    stb.ld_lim     = wr_ok & ~mode_q & (ofs_e'(addr) == OFS_HI_LIM);
    stb.ld_hi      = wr_ok &  mode_q & (ofs_e'(addr) == OFS_HI_LIM);
    stb.ld_lo      = wr_ok &  mode_q & (ofs_e'(addr) == OFS_LO_CNT);
    stb.ld_run     = wr_ok &           (ofs_e'(addr) == OFS_RUN);
    stb.rd_lim_clr = rd_ok & ~mode_q & (ofs_e'(addr) == OFS_HI_LIM);
  end

  dmt_count_core #(
    .DATA_W   (DATA_W),
    .UNIT_LSB (UNIT_LSB),
    .USR_W    (USR_W),
    .SYS_W    (SYS_W),
    .LO_W     (LO_W),
    .HI_W     (HI_W)
  ) core_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .mode_q     (mode_q),
    .enter_user (enter_user),
    .leave_user (leave_user),
    .stb        (stb),
    .wdata      (wdata),
    .cnt        (cnt),
    .lim        (lim),
    .reached    (reached),
    .run        (run),
    .irq        (irq)
  );

  dmt_read_port #(
    .DATA_W   (DATA_W),
    .UNIT_LSB (UNIT_LSB),
    .USR_W    (USR_W),
    .SYS_W    (SYS_W),
    .LO_W     (LO_W),
    .HI_W     (HI_W)
  ) rd_i (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .mode_chg (mode_chg),
    .addr     (addr),
    .mode_q   (mode_q),
    .cnt      (cnt),
    .lim      (lim),
    .reached  (reached),
    .run      (run),
    .rdata    (rdata)
  );

endmodule

// File: rtl/dmt_channel_chk.sv
module dmt_channel_chk #(
  parameter int DATA_W   = 32,
  parameter int UNIT_LSB = 9,
  parameter int USR_W    = 54,
  parameter int SYS_W    = 22
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              user_mode,
  input logic              wr_en,
  input logic              rd_en,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic              mode_q,
  input logic [USR_W-1:0]  cnt,
  input logic [SYS_W-1:0]  lim,
  input logic              reached,
  input logic              run
);

  // R9
  no_user_irq_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q |-> !irq);

  // R3
  irq_has_reach_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> reached);

  // R10
  enter_user_chk: assert property (@(posedge clk) disable iff (rst)
    (user_mode && !mode_q) |=> (!irq && lim == {SYS_W{1'b1}}));

  // R11
  leave_user_chk: assert property (@(posedge clk) disable iff (rst)
    (!user_mode && mode_q) |=> (cnt == '0));

  // R4
  sys_runs_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !mode_q && !user_mode && !wr_en)
      |=> (cnt == $past(cnt) + 1'b1 || cnt == '0));

  // R8
  user_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q && user_mode && !run && !wr_en) |=> $stable(cnt));

  // R6
  low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd1) |=> (rdata[UNIT_LSB-1:0] == '0));

  // R5
  run_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd3)
      |=> (rdata[DATA_W-1:1] == '0 && rdata[0] == $past(run)));

endmodule

bind dmt_channel dmt_channel_chk #(
  .DATA_W   (DATA_W),
  .UNIT_LSB (UNIT_LSB),
  .USR_W    (USR_W),
  .SYS_W    (SYS_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .user_mode (user_mode),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .rdata     (rdata),
  .irq       (irq),
  .mode_q    (mode_q),
  .cnt       (cnt),
  .lim       (lim),
  .reached   (reached),
  .run       (run)
);

// File: tb/dmt_channel_tb_top.sv
module dmt_channel_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        user_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dmt_channel dut_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .user_mode (user_mode),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .irq       (irq)
  );

  // Vector: kind, offset, data (or tick count / mode), expected rdata,
  // expected irq after the step, requirement number.
  typedef logic [72:0] vec_t;
  localparam logic [1:0] K_WR = 2'd0;
  localparam logic [1:0] K_RD = 2'd1;
  localparam logic [1:0] K_TK = 2'd2;
  localparam logic [1:0] K_MD = 2'd3;
  localparam int NV = 74;

  localparam vec_t VEC [NV] = '{
    // R1 reset view
    {K_RD, 2'd3, 32'h0, 32'h00000001, 1'b0, 4'd1},          // 0
    {K_RD, 2'd0, 32'h0, 32'h00000000, 1'b0, 4'd1},          // 1
    {K_RD, 2'd1, 32'h0, 32'h00000000, 1'b0, 4'd1},          // 2
    // R13 spare offset
    {K_RD, 2'd2, 32'h0, 32'h00000000, 1'b0, 4'd13},         // 3
    // R2 R3 limit of five units
    {K_WR, 2'd0, 32'h00000A00, 32'h0, 1'b0, 4'd2},          // 4
    {K_TK, 2'd0, 32'd3, 32'h0, 1'b0, 4'd3},                 // 5
    {K_RD, 2'd1, 32'h0, 32'h00000600, 1'b0, 4'd3},          // 6
    {K_TK, 2'd0, 32'd2, 32'h0, 1'b1, 4'd3},                 // 7
    {K_RD, 2'd1, 32'h0, 32'h80000000, 1'b1, 4'd3},          // 8
    {K_RD, 2'd0, 32'h0, 32'h00000A00, 1'b0, 4'd2},          // 9
    {K_RD, 2'd1, 32'h0, 32'h00000000, 1'b0, 4'd2},          // 10
    // R4 low-word write ignored in counter mode
    {K_WR, 2'd1, 32'h12345600, 32'h0, 1'b0, 4'd4},          // 11
    {K_RD, 2'd1, 32'h0, 32'h00000000, 1'b0, 4'd4},          // 12
    // R5 run bit
    {K_WR, 2'd3, 32'h0, 32'h0, 1'b0, 4'd5},                 // 13
    {K_RD, 2'd3, 32'h0, 32'h00000000, 1'b0, 4'd5},          // 14
    // R4 counting with run clear
    {K_TK, 2'd0, 32'd2, 32'h0, 1'b0, 4'd4},                 // 15
    {K_RD, 2'd1, 32'h0, 32'h00000400, 1'b0, 4'd4},          // 16
    // R2 R3 limit of one unit, then limit write keeps reached
    {K_WR, 2'd0, 32'h00000200, 32'h0, 1'b0, 4'd2},          // 17
    {K_TK, 2'd0, 32'd1, 32'h0, 1'b1, 4'd3},                 // 18
    {K_WR, 2'd0, 32'h00000A00, 32'h0, 1'b0, 4'd2},          // 19
    {K_RD, 2'd1, 32'h0, 32'h80000000, 1'b0, 4'd2},          // 20
    {K_RD, 2'd0, 32'h0, 32'h00000A00, 1'b0, 4'd2},          // 21
    {K_TK, 2'd0, 32'd2, 32'h0, 1'b0, 4'd4},                 // 22
    {K_RD, 2'd1, 32'h0, 32'h00000400, 1'b0, 4'd4},          // 23
    // R10 enter user mode with run clear
    {K_MD, 2'd0, 32'd1, 32'h0, 1'b0, 4'd10},                // 24
    {K_TK, 2'd0, 32'd3, 32'h0, 1'b0, 4'd8},                 // 25
    {K_RD, 2'd1, 32'h0, 32'h00000400, 1'b0, 4'd6},          // 26
    {K_RD, 2'd0, 32'h0, 32'h00000000, 1'b0, 4'd6},          // 27
    // R8 start and count
    {K_WR, 2'd3, 32'h00000001, 32'h0, 1'b0, 4'd5},          // 28
    {K_TK, 2'd0, 32'd4, 32'h0, 1'b0, 4'd8},                 // 29
    {K_RD, 2'd1, 32'h0, 32'h00000C00, 1'b0, 4'd8},          // 30
    // R7 loads
    {K_WR, 2'd0, 32'h12345678, 32'h0, 1'b0, 4'd7},          // 31
    {K_RD, 2'd0, 32'h0, 32'h12345678, 1'b0, 4'd7},          // 32
    {K_WR, 2'd1, 32'hFFFFFE00, 32'h0, 1'b0, 4'd7},          // 33
    {K_WR, 2'd0, 32'h7FFFFFFF, 32'h0, 1'b0, 4'd7},          // 34
    {K_RD, 2'd1, 32'h0, 32'hFFFFFE00, 1'b0, 4'd7},          // 35
    {K_RD, 2'd0, 32'h0, 32'h7FFFFFFF, 1'b0, 4'd7},          // 36
    // R8 R9 wrap at maximum, no interrupt
    {K_TK, 2'd0, 32'd1, 32'h0, 1'b0, 4'd9},                 // 37
    {K_RD, 2'd1, 32'h0, 32'h00000000, 1'b0, 4'd8},          // 38
    {K_RD, 2'd0, 32'h0, 32'h80000000, 1'b0, 4'd8},          // 39
    {K_RD, 2'd0, 32'h0, 32'h80000000, 1'b0, 4'd6},          // 40
    // R8 carry into high word, R7 clears reached
    {K_WR, 2'd1, 32'hFFFFFE00, 32'h0, 1'b0, 4'd7},          // 41
    {K_WR, 2'd0, 32'h00000005, 32'h0, 1'b0, 4'd7},          // 42
    {K_TK, 2'd0, 32'd1, 32'h0, 1'b0, 4'd8},                 // 43
    {K_RD, 2'd0, 32'h0, 32'h00000006, 1'b0, 4'd8},          // 44
    {K_RD, 2'd1, 32'h0, 32'h00000000, 1'b0, 4'd8},          // 45
    // R12 capture of the high word
    {K_WR, 2'd1, 32'hFFFFFE00, 32'h0, 1'b0, 4'd12},         // 46
    {K_WR, 2'd0, 32'h00000010, 32'h0, 1'b0, 4'd12},         // 47
    {K_RD, 2'd1, 32'h0, 32'hFFFFFE00, 1'b0, 4'd12},         // 48
    {K_TK, 2'd0, 32'd1, 32'h0, 1'b0, 4'd12},                // 49
    {K_RD, 2'd0, 32'h0, 32'h00000010, 1'b0, 4'd12},         // 50
    {K_RD, 2'd0, 32'h0, 32'h00000011, 1'b0, 4'd12},         // 51
    // R8 stop holds
    {K_WR, 2'd3, 32'h0, 32'h0, 1'b0, 4'd5},                 // 52
    {K_TK, 2'd0, 32'd5, 32'h0, 1'b0, 4'd8},                 // 53
    {K_RD, 2'd1, 32'h0, 32'h00000000, 1'b0, 4'd8},          // 54
    {K_RD, 2'd0, 32'h0, 32'h00000011, 1'b0, 4'd8},          // 55
    // R11 back to counter mode
    {K_MD, 2'd0, 32'd0, 32'h0, 1'b0, 4'd11},                // 56
    {K_RD, 2'd0, 32'h0, 32'h7FFFFE00, 1'b0, 4'd10},         // 57
    {K_TK, 2'd0, 32'd3, 32'h0, 1'b0, 4'd11},                // 58
    {K_RD, 2'd1, 32'h0, 32'h00000600, 1'b0, 4'd11},         // 59
    {K_RD, 2'd3, 32'h0, 32'h00000000, 1'b0, 4'd11},         // 60
    // R10 pending interrupt dropped on entry
    {K_WR, 2'd0, 32'h00000200, 32'h0, 1'b0, 4'd2},          // 61
    {K_TK, 2'd0, 32'd1, 32'h0, 1'b1, 4'd3},                 // 62
    {K_MD, 2'd0, 32'd1, 32'h0, 1'b0, 4'd10},                // 63
    {K_RD, 2'd0, 32'h0, 32'h80000000, 1'b0, 4'd10},         // 64
    {K_MD, 2'd0, 32'd0, 32'h0, 1'b0, 4'd11},                // 65
    {K_RD, 2'd0, 32'h0, 32'h7FFFFE00, 1'b0, 4'd10},         // 66
    // R3 free run with limit zero
    {K_WR, 2'd0, 32'h00000000, 32'h0, 1'b0, 4'd3},          // 67
    {K_TK, 2'd0, 32'd5, 32'h0, 1'b0, 4'd3},                 // 68
    {K_RD, 2'd1, 32'h0, 32'h00000A00, 1'b0, 4'd3},          // 69
    // R10 entry with run set keeps counting
    {K_WR, 2'd3, 32'h00000001, 32'h0, 1'b0, 4'd5},          // 70
    {K_MD, 2'd0, 32'd1, 32'h0, 1'b0, 4'd10},                // 71
    {K_TK, 2'd0, 32'd2, 32'h0, 1'b0, 4'd10},                // 72
    {K_RD, 2'd1, 32'h0, 32'h00000E00, 1'b0, 4'd10}          // 73
  };

  task automatic check(input string what, input int req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Each step starts just after a falling edge and ends on one.
  task automatic run_step(input vec_t v);
    logic [1:0]  kind;
    logic [31:0] dat;
    kind = v[72:71];
    dat  = v[68:37];
    case (kind)
      K_WR: begin
        wr_en = 1'b1; addr = v[70:69]; wdata = dat;
        @(negedge clk);
        wr_en = 1'b0;
      end
      K_RD: begin
        rd_en = 1'b1; addr = v[70:69];
        @(negedge clk);
        rd_en = 1'b0;
        check("rdata", int'(v[3:0]), rdata, v[36:5]);
      end
      K_TK: begin
        tick = 1'b1;
        repeat (int'(dat)) @(negedge clk);
        tick = 1'b0;
      end
      default: begin
        user_mode = dat[0];
        repeat (2) @(negedge clk);
      end
    endcase
    check("irq", int'(v[3:0]), {31'b0, irq}, {31'b0, v[4]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 outputs right after reset
    check("irq after reset", 1, {31'b0, irq}, 32'h0);
    check("rdata after reset", 1, rdata, 32'h0);

    for (int i = 0; i < NV; i++) run_step(VEC[i]);

    // R1 reset in mid-run restores the defaults
    user_mode = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("irq after second reset", 1, {31'b0, irq}, 32'h0);
    run_step({K_RD, 2'd3, 32'h0, 32'h00000001, 1'b0, 4'd1});
    run_step({K_RD, 2'd0, 32'h0, 32'h00000000, 1'b0, 4'd1});
    run_step({K_RD, 2'd1, 32'h0, 32'h00000000, 1'b0, 4'd1});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule